// File: doc/BRIEF.md
# Loopback Latency Measurement Timer

This block times how long a packet takes to go from the user transmit interface of a 10G Ethernet MAC/PCS path, through a serial loopback, and back out on the receive side. A cycle counter in the transmit/timer clock domain starts on the first accepted beat of a transmit packet. It stops when a chosen receive-side frame-start marker is seen. The marker is detected in the receive clock domain and carried across into the timer domain before it can stop the count, so every result includes the clock-domain-crossing delay.

Three stop markers are available, one for each layer. The first is the first user payload beat on the receive stream. The second is the MAC start-of-frame delimiter in the 4-lane receive data/control group. The third is the PCS start control character. Each finished run produces a latency value with a one-cycle valid pulse, and updates a running minimum, maximum, saturating sum and packet count. A sticky flag reports a transmit start that arrives while a run is in progress. A programmable timeout ends runs that never see their stop marker.

Top module: `lat_loop_timer`

## Requirements
- R1: A run starts on a transmit beat with tx_valid_i and tx_ready_i both high that is the first beat of a packet, meaning the first beat after reset or after a beat with tx_last_i high. Later beats of the same packet neither restart the run nor set the overlap flag.
- R2: With stop_sel_i = 0, the stop event is the first rx_valid_i beat of a receive packet, where packets are delimited by rx_last_i. If that beat is sampled N rx_clk_i edges after the start edge, with the two clocks identical, then lat_o = N + 3. This figure includes the toggle crossing: a receive-domain toggle flop, two synchronizer flops and an edge-detect flop.
- R3: With stop_sel_i = 1, the stop event is a data byte 0xD5 (control bit 0) in any lane whose preceding byte in stream order is a data byte 0x55. Lane 0 is bits 7:0 and comes first, and the byte before lane 0 is lane 3 of the previous word. A 0xD5 without a 0x55 data byte before it is not an event.
- R4: With stop_sel_i = 2, the stop event is byte 0xFB with its control bit set, in lane 0 only. A 0xFB in any other lane is not an event.
- R5: For a frame of start-character word, preamble/delimiter word, then payload beat on consecutive cycles, the start-character and delimiter modes report 2 and 1 cycles less, respectively, than payload mode.
- R6: A receive event while no run is in progress has no effect on any output.
- R7: A packet-start beat while a run is in progress is ignored and sets the sticky overlap_o flag. The run in progress keeps its original start.
- R8: If timeout_i is nonzero and the elapsed count reaches timeout_i without a stop, the run ends, timeout_o is set sticky, and no latency or statistic is updated.
- R9: Each completed run gives one lat_valid_o pulse with lat_o. In the same cycle lat_num_o increments and lat_min_o / lat_max_o take the new extreme.
- R10: lat_sum_o accumulates every completed latency and saturates at all ones instead of wrapping.
- R11: After reset or a stat_clr_i cycle: lat_min_o is all ones; lat_max_o, lat_sum_o and lat_num_o are 0; overlap_o and timeout_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer / transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| tx_valid_i | input | 1 | Transmit user stream valid |
| tx_ready_i | input | 1 | Transmit user stream ready |
| tx_last_i | input | 1 | Transmit user stream last beat |
| rx_clk_i | input | 1 | Receive clock |
| rx_data_i | input | 8*LANES | Receive lane data, lane 0 in bits 7:0 |
| rx_ctrl_i | input | LANES | Receive lane control bits |
| rx_valid_i | input | 1 | Receive user stream valid |
| rx_last_i | input | 1 | Receive user stream last beat |
| stop_sel_i | input | 2 | 0 payload, 1 delimiter, 2 start character |
| timeout_i | input | CNT_W | Timeout in cycles, 0 disables |
| stat_clr_i | input | 1 | Synchronous clear of statistics and flags |
| lat_o | output | CNT_W | Last measured latency in cycles |
| lat_valid_o | output | 1 | One-cycle pulse when lat_o updates |
| lat_min_o | output | CNT_W | Smallest latency since clear |
| lat_max_o | output | CNT_W | Largest latency since clear |
| lat_sum_o | output | SUM_W | Saturating sum of latencies |
| lat_num_o | output | NUM_W | Count of completed runs |
| overlap_o | output | 1 | Sticky: start seen while running |
| timeout_o | output | 1 | Sticky: a run timed out |

## Verification
The bench checks that the three stop markers of one frame give latencies that are exactly 0, 1 and 2 cycles apart. A missing or extra synchronizer stage would shift all three results, and a wrongly timed marker would break the spacing. It places the delimiter in lane 1 and in lane 0, so the lane-0 case depends on a 0x55 byte carried over from the previous word. It also feeds a delimiter without a preamble byte before it and a start character in a non-zero lane; both must time out rather than stop the run. Overlapping starts, continuation beats, receive events while idle and a long run that drives the sum into saturation would each show up as a wrong latency, a wrong flag or a statistic that changed when it should not.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    STOP_PAYLOAD = 2'd0,
    STOP_SFD     = 2'd1,
    STOP_START   = 2'd2
  } stop_sel_e;

  localparam logic [7:0] PRE_BYTE   = 8'h55;
  localparam logic [7:0] SFD_BYTE   = 8'hD5;
  localparam logic [7:0] START_BYTE = 8'hFB;
endpackage

// File: rtl/lat_rx_marker.sv
module lat_rx_marker
  import lat_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         sel_i,
  input  logic [8*LANES-1:0] data_i,
  input  logic [LANES-1:0]   ctrl_i,
  input  logic               valid_i,
  input  logic               last_i,
  output logic               evt_tgl_o
);
  logic [LANES-1:0] pre_b, sfd_b;
  logic             prev_pre_q, first_q, tgl_q;
  logic             start_hit, pay_hit, evt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic prev_pre;
    assign pre_b[i] = !ctrl_i[i] && (data_i[8*i +: 8] == PRE_BYTE);
    if (i == 0) begin : g_first
      assign prev_pre = prev_pre_q;  // byte before lane 0 is last lane of prior word
    end else begin : g_rest
      assign prev_pre = pre_b[i-1];
    end
    assign sfd_b[i] = !ctrl_i[i] && (data_i[8*i +: 8] == SFD_BYTE) && prev_pre;
  end

  assign start_hit = ctrl_i[0] && (data_i[7:0] == START_BYTE);
  assign pay_hit   = valid_i && first_q;

  always_comb begin
    unique case (stop_sel_e'(sel_i))
      STOP_SFD:   evt = |sfd_b;
      STOP_START: evt = start_hit;
      default:    evt = pay_hit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_pre_q <= 1'b0;
      first_q    <= 1'b1;
      tgl_q      <= 1'b0;
    end else begin
      prev_pre_q <= pre_b[LANES-1];
      if (valid_i) first_q <= last_i;
      if (evt) tgl_q <= ~tgl_q;
    end
  end

  assign evt_tgl_o = tgl_q;
endmodule

// File: rtl/lat_tgl_sync.sv
module lat_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  // STAGES synchronizer flops plus one flop for edge detection
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int CNT_W = 16,
  parameter int SUM_W = 32,
  parameter int NUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] lat_o,
  output logic             lat_valid_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o,
  output logic [SUM_W-1:0] sum_o,
  output logic [NUM_W-1:0] num_o,
  output logic             overlap_o,
  output logic             timeout_o
);
  localparam int AW = ((SUM_W > CNT_W) ? SUM_W : CNT_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [NUM_W-1:0] NUM_MAX = '1;
  localparam logic [AW-1:0]    SUM_MAX = {{(AW-SUM_W){1'b0}}, {SUM_W{1'b1}}};

  logic             run_q, valid_q, ovl_q, tmo_q;
  logic [CNT_W-1:0] cnt_q, lat_q, elapsed, min_q, max_q;
  logic [SUM_W-1:0] sum_q;
  logic [NUM_W-1:0] num_q;
  logic [AW-1:0]    acc;
  logic             fire, expire;

  assign elapsed = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign fire    = run_q && stop_i;
  assign expire  = run_q && !stop_i && (tmo_i != '0) && (elapsed == tmo_i);
  assign acc     = AW'(sum_q) + AW'(elapsed);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      lat_q   <= '0;
      valid_q <= 1'b0;
      ovl_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) lat_q <= elapsed;
      if (run_q) begin
        if (fire || expire) run_q <= 1'b0;
        else                cnt_q <= elapsed;
      end else if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end
      if (clr_i) begin
        ovl_q <= 1'b0;
        tmo_q <= 1'b0;
      end else begin
        if (run_q && start_i) ovl_q <= 1'b1;
        if (expire)           tmo_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= CNT_MAX;
      max_q <= '0;
      sum_q <= '0;
      num_q <= '0;
    end else if (clr_i) begin
      min_q <= CNT_MAX;
      max_q <= '0;
      sum_q <= '0;
      num_q <= '0;
    end else if (fire) begin
      if (elapsed < min_q) min_q <= elapsed;
      if (elapsed > max_q) max_q <= elapsed;
      sum_q <= (acc > SUM_MAX) ? SUM_MAX[SUM_W-1:0] : acc[SUM_W-1:0];
      if (num_q != NUM_MAX) num_q <= num_q + 1'b1;
    end
  end

  assign lat_o       = lat_q;
  assign lat_valid_o = valid_q;
  assign min_o       = min_q;
  assign max_o       = max_q;
  assign sum_o       = sum_q;
  assign num_o       = num_q;
  assign overlap_o   = ovl_q;
  assign timeout_o   = tmo_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_valid_o |=> !lat_valid_o);
  a_r9_min_le_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_o != '0) |-> (min_o <= max_o));
  a_r10_sum_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (sum_o >= $past(sum_o)));
  a_r7_overlap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overlap_o && !clr_i) |=> overlap_o);
  a_r8_timeout_no_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($stable(num_o) && !lat_valid_o));
endmodule

// File: rtl/lat_loop_timer.sv
module lat_loop_timer #(
  parameter int LANES       = 4,
  parameter int CNT_W       = 16,
  parameter int SUM_W       = 32,
  parameter int NUM_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_valid_i,
  input  logic               tx_ready_i,
  input  logic               tx_last_i,
  input  logic               rx_clk_i,
  input  logic [8*LANES-1:0] rx_data_i,
  input  logic [LANES-1:0]   rx_ctrl_i,
  input  logic               rx_valid_i,
  input  logic               rx_last_i,
  input  logic [1:0]         stop_sel_i,
  input  logic [CNT_W-1:0]   timeout_i,
  input  logic               stat_clr_i,
  output logic [CNT_W-1:0]   lat_o,
  output logic               lat_valid_o,
  output logic [CNT_W-1:0]   lat_min_o,
  output logic [CNT_W-1:0]   lat_max_o,
  output logic [SUM_W-1:0]   lat_sum_o,
  output logic [NUM_W-1:0]   lat_num_o,
  output logic               overlap_o,
  output logic               timeout_o
);
  logic tx_first_q, tx_beat, tx_start, evt_tgl, stop_pulse;

  assign tx_beat  = tx_valid_i && tx_ready_i;
  assign tx_start = tx_beat && tx_first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_first_q <= 1'b1;
    else if (tx_beat) tx_first_q <= tx_last_i;
  end

  lat_rx_marker #(.LANES(LANES)) u_marker (
    .clk_i     (rx_clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (stop_sel_i),
    .data_i    (rx_data_i),
    .ctrl_i    (rx_ctrl_i),
    .valid_i   (rx_valid_i),
    .last_i    (rx_last_i),
    .evt_tgl_o (evt_tgl)
  );

  lat_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (evt_tgl),
    .pulse_o (stop_pulse)
  );

  lat_timer #(.CNT_W(CNT_W), .SUM_W(SUM_W), .NUM_W(NUM_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (tx_start),
    .stop_i      (stop_pulse),
    .tmo_i       (timeout_i),
    .clr_i       (stat_clr_i),
    .lat_o       (lat_o),
    .lat_valid_o (lat_valid_o),
    .min_o       (lat_min_o),
    .max_o       (lat_max_o),
    .sum_o       (lat_sum_o),
    .num_o       (lat_num_o),
    .overlap_o   (overlap_o),
    .timeout_o   (timeout_o)
  );

  a_r1_cont_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_beat && !tx_first_q && !stat_clr_i && !overlap_o) |=> !overlap_o);
endmodule

// File: tb/lat_loop_timer_tb.sv
`timescale 1ns/1ps
module lat_loop_timer_tb;
  localparam int CNT_W = 16;
  localparam int SUM_W = 8;
  localparam int NUM_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 0, tx_ready = 0, tx_last = 0;
  logic [31:0] rx_data = 32'h07070707;
  logic [3:0]  rx_ctrl = 4'hF;
  logic rx_valid = 0, rx_last = 0, clr = 0;
  logic [1:0] sel = 0;
  logic [CNT_W-1:0] tmo = 16'd30;
  logic [CNT_W-1:0] lat, lmin, lmax;
  logic [SUM_W-1:0] lsum;
  logic [NUM_W-1:0] lnum;
  logic lat_valid, ovl, tout;

  int checks = 0, errors = 0, n_pulse = 0, last_lat = 0;
  int m_min = 65535, m_max = 0, m_sum = 0, m_num = 0;
  int l_pay, l_sfd, l_st;

  always #2.5 clk = ~clk;

  lat_loop_timer #(.CNT_W(CNT_W), .SUM_W(SUM_W), .NUM_W(NUM_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_valid_i(tx_valid), .tx_ready_i(tx_ready),
    .tx_last_i(tx_last), .rx_clk_i(clk), .rx_data_i(rx_data), .rx_ctrl_i(rx_ctrl),
    .rx_valid_i(rx_valid), .rx_last_i(rx_last), .stop_sel_i(sel), .timeout_i(tmo),
    .stat_clr_i(clr), .lat_o(lat), .lat_valid_o(lat_valid), .lat_min_o(lmin),
    .lat_max_o(lmax), .lat_sum_o(lsum), .lat_num_o(lnum), .overlap_o(ovl),
    .timeout_o(tout)
  );

  always @(negedge clk) if (lat_valid) begin
    n_pulse++;
    last_lat = int'(lat);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic note(input int v);
    if (v < m_min) m_min = v;
    if (v > m_max) m_max = v;
    m_sum = (m_sum + v > 255) ? 255 : m_sum + v;
    m_num++;
  endtask

  task automatic chk_stats(input string tag);
    chk({tag, " min"}, int'(lmin), m_min);
    chk({tag, " max"}, int'(lmax), m_max);
    chk({tag, " sum"}, int'(lsum), m_sum);
    chk({tag, " num"}, int'(lnum), m_num);
  endtask

  // three receive words on consecutive edges, starting at the current negedge
  task automatic drive_rx(input logic [31:0] w0, input logic [3:0] c0,
                          input logic [31:0] w1, input logic [3:0] c1);
    rx_data = w0; rx_ctrl = c0;
    @(negedge clk);
    rx_data = w1; rx_ctrl = c1;
    @(negedge clk);
    rx_data = 32'hA1B2C3D4; rx_ctrl = 4'h0; rx_valid = 1; rx_last = 1;
    @(negedge clk);
    rx_data = 32'h07070707; rx_ctrl = 4'hF; rx_valid = 0; rx_last = 0;
  endtask

  // start beat at edge T0, first rx word at edge T0+gap; optional extra tx beat at T0+xa+1
  task automatic run_one(input logic [1:0] m, input int gap, input logic l0,
                         input int xa, input logic xl,
                         input logic [31:0] w0, input logic [3:0] c0,
                         input logic [31:0] w1, input logic [3:0] c1, input int wait_n);
    @(negedge clk);
    sel = m; tx_valid = 1; tx_ready = 1; tx_last = l0;
    @(posedge clk);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      tx_valid = (xa != 0 && i == xa);
      tx_last  = xl;
    end
    drive_rx(w0, c0, w1, c1);
    repeat (wait_n) @(negedge clk);
  endtask

  localparam logic [31:0] W0 = 32'h555555FB;
  localparam logic [3:0]  C0 = 4'b0001;
  localparam logic [31:0] W1 = 32'hD5555555;

  task automatic t_reset;
    chk("R11 reset min", int'(lmin), 65535);
    chk("R11 reset max", int'(lmax), 0);
    chk("R11 reset sum", int'(lsum), 0);
    chk("R11 reset num", int'(lnum), 0);
    chk("R11 reset flags", {30'd0, ovl, tout}, 0);
    chk("R11 reset valid", int'(lat_valid), 0);
  endtask

  task automatic t_modes;
    int p;
    p = n_pulse;
    run_one(2'd2, 6, 1, 0, 1, W0, C0, W1, 4'h0, 6);
    chk("R4 start pulse", n_pulse - p, 1); chk("R4 start lat", last_lat, 9);
    l_st = last_lat; note(9);
    p = n_pulse;
    run_one(2'd1, 6, 1, 0, 1, W0, C0, W1, 4'h0, 6);
    chk("R3 sfd pulse", n_pulse - p, 1); chk("R3 sfd lat", last_lat, 10);
    l_sfd = last_lat; note(10);
    p = n_pulse;
    run_one(2'd0, 6, 1, 0, 1, W0, C0, W1, 4'h0, 6);
    chk("R2 payload pulse", n_pulse - p, 1); chk("R2 payload lat", last_lat, 11);
    l_pay = last_lat; note(11);
    chk("R5 payload-sfd", l_pay - l_sfd, 1);
    chk("R5 payload-start", l_pay - l_st, 2);
  endtask

  task automatic t_sfd_lanes;
    run_one(2'd1, 6, 1, 0, 1, W0, C0, 32'h2211D555, 4'h0, 6);
    chk("R3 sfd lane1", last_lat, 10); note(10);
    run_one(2'd1, 6, 1, 0, 1, W0, C0, 32'h332211D5, 4'h0, 6);
    chk("R3 sfd lane0 carried", last_lat, 10); note(10);
    chk_stats("R9 stats");
  endtask

  task automatic t_no_marker;
    int p;
    p = n_pulse;
    run_one(2'd1, 6, 1, 0, 1, W0, C0, 32'hD5AA5555, 4'h0, 45);
    chk("R3 no pre no pulse", n_pulse - p, 0);
    chk("R8 timeout flag", int'(tout), 1);
    chk_stats("R8 stats kept");
    p = n_pulse;
    run_one(2'd2, 6, 1, 0, 1, 32'h55FB5555, 4'b0100, W1, 4'h0, 45);
    chk("R4 lane2 start ignored", n_pulse - p, 0);
    chk("R8 num kept", int'(lnum), m_num);
  endtask

  task automatic t_idle_rx;
    int p;
    p = n_pulse;
    @(negedge clk); sel = 2'd2;
    drive_rx(W0, C0, W1, 4'h0);
    repeat (8) @(negedge clk);
    chk("R6 idle no pulse", n_pulse - p, 0);
    chk_stats("R6 idle stats");
  endtask

  task automatic t_cont_beat;
    clr = 1; @(negedge clk); clr = 0;   // clears timeout flag and stats
    m_min = 65535; m_max = 0; m_sum = 0; m_num = 0;
    run_one(2'd2, 6, 0, 1, 1, W0, C0, W1, 4'h0, 6);
    chk("R1 continuation lat", last_lat, 9); note(9);
    chk("R1 no overlap", int'(ovl), 0);
  endtask

  task automatic t_overlap;
    run_one(2'd2, 8, 1, 2, 1, W0, C0, W1, 4'h0, 6);
    chk("R7 lat from first start", last_lat, 11); note(11);
    chk("R7 overlap set", int'(ovl), 1);
    chk_stats("R9 stats after overlap");
  endtask

  task automatic t_clear;
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    m_min = 65535; m_max = 0; m_sum = 0; m_num = 0;
    chk_stats("R11 clear");
    chk("R11 clear overlap", int'(ovl), 0);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 30; k++) begin
      run_one(2'd2, 7, 1, 0, 1, W0, C0, W1, 4'h0, 6);
      note(10);
    end
    chk("R10 sum saturated", int'(lsum), 255);
    chk_stats("R10 stats");
  endtask

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_modes();
    t_sfd_lanes();
    t_no_marker();
    t_idle_rx();
    t_cont_beat();
    t_overlap();
    t_clear();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule